// File: doc/BRIEF.md
# Debug Event Status Register

This block holds the sticky status word a processor core keeps for its debug logic. The core sends each debug event as a one-cycle strobe: instruction complete, branch taken, interrupt taken, trap, return, instruction-address compare hits and data-address compare read or write hits. A strobe is latched into its own flag only when the debug control register enables that event. Each data-address compare unit has a 2-bit mode that selects whether read hits, write hits or both may be recorded. An active-low unconditional debug pin is synchronized and acted on at its falling edge. It is recorded only when internal debug mode is on.

Software reads the whole word and clears flags by writing ones to them. When the machine-state debug-enable bit is off, any recorded event also sets an imprecise flag. This marks the event as one that could not raise an interrupt when it happened. A 2-bit field keeps the reset history: a hard reset sets its upper bit and a soft-reset strobe sets its lower bit. While debug-enable is on, the block requests a debug interrupt as long as any event flag is set.

Top module: `dbg_evt_status`

## Requirements
- R1: Each flag is sticky. A write clears exactly the flags whose data bit is 1. A write of 0 to a bit leaves that flag as it is, and without a write no flag ever drops.
- R2: `evt_i` bit 0 (instruction complete), 1 (branch taken), 2 (interrupt taken), 3 (trap) and 4 (return) set read-word bits 27, 26, 25, 24 and 15 respectively. A strobe sets its bit only when the same bit of `evt_en_i` is 1 in that cycle.
- R3: `iac_hit_i[k]` sets read-word bit 23-k only when `iac_en_i[k]` is 1.
- R4: For data-address compare unit k, the mode is `dac_mode_i[2k+1:2k]`. A read hit sets bit 19-2k only if mode bit 1 is set (modes 10, 11). A write hit sets bit 18-2k only if mode bit 0 is set (modes 01, 11).
- R5: `ude_n_i` is active low. It passes through two synchronizing flops and an edge detector, so a falling edge sets bit 30 on the third rising clock edge after the edge, and only when `idm_i` is 1. Holding the pin low produces a single event.
- R6: Bit 31 is set in the same cycle as any event flag (R2 to R5) whenever `msr_de_i` is 0.
- R7: Bits 29:28 form the reset-history field. Hard reset (`rst_ni` low) loads 10, a `soft_rst_i` strobe sets bit 28, and both bits clear by writing 1.
- R8: Bits 21:20 and 14:0 always read 0, and writing them has no effect.
- R9: When an event and a clearing write hit the same flag in one cycle, the flag ends up set.
- R10: `dbg_irq_o` is 1 exactly when `msr_de_i` is 1 and at least one of bits 30, 27:22 or 19:15 is set. Bits 31 and 29:28 do not request an interrupt.
- R11: After hard reset the read word is 0x2000_0000 and `dbg_irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Hard reset, active low, asynchronous |
| evt_i | input | 5 | Strobes for the simple events |
| evt_en_i | input | 5 | Enables for the simple events |
| iac_hit_i | input | NUM_IAC | Instruction-address compare hit strobes |
| iac_en_i | input | NUM_IAC | Instruction-address compare enables |
| dac_rd_i | input | NUM_DAC | Data-address compare read-hit strobes |
| dac_wr_i | input | NUM_DAC | Data-address compare write-hit strobes |
| dac_mode_i | input | 2*NUM_DAC | Per-unit 2-bit read/write recording mode |
| ude_n_i | input | 1 | Unconditional debug pin, active low, asynchronous |
| idm_i | input | 1 | Internal debug mode enable |
| msr_de_i | input | 1 | Machine-state debug interrupt enable |
| soft_rst_i | input | 1 | Soft reset strobe |
| wr_en_i | input | 1 | Write strobe for the clearing write |
| wr_data_i | input | 32 | Write data, one bit clears the matching flag |
| rd_data_o | output | 32 | Current status word |
| dbg_irq_o | output | 1 | Debug interrupt request |

## Verification
On every cycle the assertions check these properties: flags never drop without a write, a set flag survives a same-cycle clear, the imprecise flag follows an event taken while interrupts are masked, disabled data-compare modes and a disabled unconditional pin record nothing, and the synchronizer emits single-cycle pulses. The bench's scenarios cover the rest. They walk each event with its enable both off and on, all four data-compare modes, partial writes and writes to reserved bits, and a pin held low across a clear. A behavioural model is compared on every clock to catch misplaced bits and wrong latencies.

// File: rtl/dbg_evt_pkg.sv
package dbg_evt_pkg;

   localparam int unsigned WORD_W    = 32;
   localparam int unsigned NUM_SIMPLE = 5;

   // read-word bit positions (bit 31 is the most significant)
   localparam int unsigned POS_IMPRECISE = 31;
   localparam int unsigned POS_UNCOND    = 30;
   localparam int unsigned POS_RST_HARD  = 29;
   localparam int unsigned POS_RST_SOFT  = 28;
   localparam int unsigned POS_IAC_BASE  = 23;
   localparam int unsigned POS_DAC_BASE  = 19;

   // simple event slots in evt_i
   localparam int unsigned EV_ICMP = 0;
   localparam int unsigned EV_BRT  = 1;
   localparam int unsigned EV_IRPT = 2;
   localparam int unsigned EV_TRAP = 3;
   localparam int unsigned EV_RET  = 4;

   function automatic int unsigned simple_pos(input int unsigned idx);
      return (idx == EV_RET) ? 15 : (27 - idx);
   endfunction

   function automatic int unsigned iac_pos(input int unsigned k);
      return POS_IAC_BASE - k;
   endfunction

   function automatic int unsigned dac_rd_pos(input int unsigned k);
      return POS_DAC_BASE - 2 * k;
   endfunction

   function automatic int unsigned dac_wr_pos(input int unsigned k);
      return POS_DAC_BASE - 2 * k - 1;
   endfunction

   // bits that may request an interrupt
   function automatic logic [WORD_W-1:0] event_bits(input int unsigned n_iac,
                                                    input int unsigned n_dac);
      logic [WORD_W-1:0] m;
      m = '0;
      m[POS_UNCOND] = 1'b1;
      for (int unsigned i = 0; i < NUM_SIMPLE; i++) m[simple_pos(i)] = 1'b1;
      for (int unsigned k = 0; k < n_iac; k++) m[iac_pos(k)] = 1'b1;
      for (int unsigned k = 0; k < n_dac; k++) begin
         m[dac_rd_pos(k)] = 1'b1;
         m[dac_wr_pos(k)] = 1'b1;
      end
      return m;
   endfunction

   // all implemented bits
   function automatic logic [WORD_W-1:0] defined_bits(input int unsigned n_iac,
                                                      input int unsigned n_dac);
      logic [WORD_W-1:0] m;
      m = event_bits(n_iac, n_dac);
      m[POS_IMPRECISE] = 1'b1;
      m[POS_RST_HARD]  = 1'b1;
      m[POS_RST_SOFT]  = 1'b1;
      return m;
   endfunction

endpackage

// File: rtl/dbg_ude_sync.sv
module dbg_ude_sync #(
   parameter int unsigned STAGES     = 2,
   parameter bit          ACTIVE_LOW = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic pin_i,
   output logic evt_o
);

   localparam logic IDLE_LVL = ACTIVE_LOW ? 1'b1 : 1'b0;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("dbg_ude_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sync_q;
   logic              prev_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sync_q <= {STAGES{IDLE_LVL}};
         prev_q <= IDLE_LVL;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], pin_i};
         prev_q <= sync_q[STAGES-1];
      end
   end

   generate
      if (ACTIVE_LOW) begin : g_fall
         assign evt_o = prev_q & ~sync_q[STAGES-1];
      end else begin : g_rise
         assign evt_o = ~prev_q & sync_q[STAGES-1];
      end
   endgenerate

   // R5
   pulse_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_o |=> !evt_o);

endmodule

// File: rtl/dbg_evt_qual.sv
module dbg_evt_qual
   import dbg_evt_pkg::*;
#(
   parameter int unsigned NUM_IAC = 2,
   parameter int unsigned NUM_DAC = 2
) (
   input  logic [NUM_SIMPLE-1:0]  evt_i,
   input  logic [NUM_SIMPLE-1:0]  evt_en_i,
   input  logic [NUM_IAC-1:0]     iac_hit_i,
   input  logic [NUM_IAC-1:0]     iac_en_i,
   input  logic [NUM_DAC-1:0]     dac_rd_i,
   input  logic [NUM_DAC-1:0]     dac_wr_i,
   input  logic [2*NUM_DAC-1:0]   dac_mode_i,
   input  logic                   ude_evt_i,
   input  logic                   idm_i,
   input  logic                   msr_de_i,
   input  logic                   soft_rst_i,
   output logic [WORD_W-1:0]      set_o,
   output logic                   evt_any_o
);

   logic [NUM_DAC-1:0] rd_allow;
   logic [NUM_DAC-1:0] wr_allow;
   logic [WORD_W-1:0]  evt_set;

   generate
      for (genvar k = 0; k < NUM_DAC; k++) begin : g_dac_mode
         assign rd_allow[k] = dac_mode_i[2*k+1];
         assign wr_allow[k] = dac_mode_i[2*k];
      end
   endgenerate

   always_comb begin
      evt_set = '0;
      for (int unsigned i = 0; i < NUM_SIMPLE; i++) begin
         evt_set[simple_pos(i)] = evt_i[i] & evt_en_i[i];
      end
      for (int unsigned k = 0; k < NUM_IAC; k++) begin
         evt_set[iac_pos(k)] = iac_hit_i[k] & iac_en_i[k];
      end
      for (int unsigned k = 0; k < NUM_DAC; k++) begin
         evt_set[dac_rd_pos(k)] = dac_rd_i[k] & rd_allow[k];
         evt_set[dac_wr_pos(k)] = dac_wr_i[k] & wr_allow[k];
      end
      evt_set[POS_UNCOND] = ude_evt_i & idm_i;
   end

   assign evt_any_o = |evt_set;

   always_comb begin
      set_o = evt_set;
      set_o[POS_IMPRECISE] = evt_any_o & ~msr_de_i;
      set_o[POS_RST_SOFT]  = soft_rst_i;
   end

endmodule

// File: rtl/dbg_w1c_reg.sv
module dbg_w1c_reg #(
   parameter int unsigned    W         = 32,
   parameter logic [W-1:0]   RST_VAL   = '0,
   parameter logic [W-1:0]   IMPL_MASK = '1
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] set_i,
   input  logic         clr_en_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] q_o
);

   localparam logic [W-1:0] RST_IMPL = RST_VAL & IMPL_MASK;

   logic [W-1:0] clr_eff;

   assign clr_eff = clr_en_i ? clr_i : '0;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_o <= RST_IMPL;
      else         q_o <= ((q_o & ~clr_eff) | set_i) & IMPL_MASK;
   end

   // R9
   set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (set_i != '0) |=> ((q_o & $past(set_i & IMPL_MASK)) == $past(set_i & IMPL_MASK)));

   // R1
   sticky_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !clr_en_i |=> ((q_o & $past(q_o)) == $past(q_o)));

endmodule

// File: rtl/dbg_evt_status.sv
module dbg_evt_status
   import dbg_evt_pkg::*;
#(
   parameter int unsigned NUM_IAC     = 2,
   parameter int unsigned NUM_DAC     = 2,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          UDE_ACT_LOW = 1'b1
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic [4:0]            evt_i,
   input  logic [4:0]            evt_en_i,
   input  logic [NUM_IAC-1:0]    iac_hit_i,
   input  logic [NUM_IAC-1:0]    iac_en_i,
   input  logic [NUM_DAC-1:0]    dac_rd_i,
   input  logic [NUM_DAC-1:0]    dac_wr_i,
   input  logic [2*NUM_DAC-1:0]  dac_mode_i,
   input  logic                  ude_n_i,
   input  logic                  idm_i,
   input  logic                  msr_de_i,
   input  logic                  soft_rst_i,
   input  logic                  wr_en_i,
   input  logic [31:0]           wr_data_i,
   output logic [31:0]           rd_data_o,
   output logic                  dbg_irq_o
);

   localparam logic [WORD_W-1:0] EVT_MASK  = event_bits(NUM_IAC, NUM_DAC);
   localparam logic [WORD_W-1:0] IMPL      = defined_bits(NUM_IAC, NUM_DAC);
   localparam logic [WORD_W-1:0] RESET_VAL = WORD_W'(1) << POS_RST_HARD;

   generate
      if (NUM_IAC < 1 || NUM_IAC > 2) begin : g_bad_iac
         $error("dbg_evt_status: NUM_IAC must be 1 or 2");
      end
      if (NUM_DAC < 1 || NUM_DAC > 2) begin : g_bad_dac
         $error("dbg_evt_status: NUM_DAC must be 1 or 2");
      end
      if (WORD_W != 32) begin : g_bad_word
         $error("dbg_evt_status: word width must be 32");
      end
   endgenerate

   logic              ude_evt;
   logic              evt_any;
   logic [WORD_W-1:0] set_vec;
   logic [WORD_W-1:0] status_q;

   dbg_ude_sync #(
      .STAGES     (SYNC_STAGES),
      .ACTIVE_LOW (UDE_ACT_LOW)
   ) i_ude_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (ude_n_i),
      .evt_o  (ude_evt)
   );

   dbg_evt_qual #(
      .NUM_IAC (NUM_IAC),
      .NUM_DAC (NUM_DAC)
   ) i_qual (
      .evt_i      (evt_i),
      .evt_en_i   (evt_en_i),
      .iac_hit_i  (iac_hit_i),
      .iac_en_i   (iac_en_i),
      .dac_rd_i   (dac_rd_i),
      .dac_wr_i   (dac_wr_i),
      .dac_mode_i (dac_mode_i),
      .ude_evt_i  (ude_evt),
      .idm_i      (idm_i),
      .msr_de_i   (msr_de_i),
      .soft_rst_i (soft_rst_i),
      .set_o      (set_vec),
      .evt_any_o  (evt_any)
   );

   dbg_w1c_reg #(
      .W         (WORD_W),
      .RST_VAL   (RESET_VAL),
      .IMPL_MASK (IMPL)
   ) i_status (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .set_i    (set_vec),
      .clr_en_i (wr_en_i),
      .clr_i    (wr_data_i),
      .q_o      (status_q)
   );

   assign rd_data_o = status_q;
   assign dbg_irq_o = msr_de_i & |(status_q & EVT_MASK);

   // R6
   imprecise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!msr_de_i && evt_any) |=> rd_data_o[POS_IMPRECISE]);

   // R10
   irq_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (msr_de_i && evt_any) |=> (dbg_irq_o || !msr_de_i));

   // R10
   irq_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !msr_de_i |-> !dbg_irq_o);

   // R5
   ude_idm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ude_evt && !idm_i) |-> !set_vec[POS_UNCOND]);

   generate
      for (genvar k = 0; k < NUM_DAC; k++) begin : g_dac_chk
         // R4
         dac_rd_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !dac_mode_i[2*k+1] |-> !set_vec[POS_DAC_BASE-2*k]);
         // R4
         dac_wr_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !dac_mode_i[2*k] |-> !set_vec[POS_DAC_BASE-2*k-1]);
      end
   endgenerate

endmodule

// File: tb/test_dbg_evt_status.sv
module test_dbg_evt_status;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  evt = '0, evt_en = '0;
   logic [1:0]  iac_hit = '0, iac_en = '0;
   logic [1:0]  dac_rd = '0, dac_wr = '0;
   logic [3:0]  dac_mode = '0;
   logic        ude_n = 1'b1, idm = 1'b0, msr_de = 1'b0, soft_rst = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic        irq;

   int total = 0, bad = 0;
   bit running = 1'b0, finished = 1'b0;

   always #10 clk = ~clk;

   dbg_evt_status i_dbg_evt_status (
      .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .evt_en_i(evt_en),
      .iac_hit_i(iac_hit), .iac_en_i(iac_en), .dac_rd_i(dac_rd), .dac_wr_i(dac_wr),
      .dac_mode_i(dac_mode), .ude_n_i(ude_n), .idm_i(idm), .msr_de_i(msr_de),
      .soft_rst_i(soft_rst), .wr_en_i(wr_en), .wr_data_i(wr_data),
      .rd_data_o(rd_data), .dbg_irq_o(irq)
   );

   // behavioural reference model
   logic [31:0] m_reg;
   bit          ude_hist[$];
   localparam logic [31:0] IRQ_BITS = 32'h4FCF_8000;
   localparam logic [31:0] DEF_BITS = 32'hFFCF_8000;

   always @(posedge clk) begin
      logic [31:0] s, c;
      bit fell;
      if (!rst_n) begin
         m_reg = 32'h2000_0000;
         ude_hist = '{1'b1, 1'b1, 1'b1};
      end else begin
         s = '0;
         fell = ude_hist[2] && !ude_hist[1];
         if (evt[0] && evt_en[0]) s[27] = 1'b1;
         if (evt[1] && evt_en[1]) s[26] = 1'b1;
         if (evt[2] && evt_en[2]) s[25] = 1'b1;
         if (evt[3] && evt_en[3]) s[24] = 1'b1;
         if (evt[4] && evt_en[4]) s[15] = 1'b1;
         if (iac_hit[0] && iac_en[0]) s[23] = 1'b1;
         if (iac_hit[1] && iac_en[1]) s[22] = 1'b1;
         if (dac_rd[0] && dac_mode[1]) s[19] = 1'b1;
         if (dac_wr[0] && dac_mode[0]) s[18] = 1'b1;
         if (dac_rd[1] && dac_mode[3]) s[17] = 1'b1;
         if (dac_wr[1] && dac_mode[2]) s[16] = 1'b1;
         if (fell && idm) s[30] = 1'b1;
         if (s != 0 && !msr_de) s[31] = 1'b1;
         if (soft_rst) s[28] = 1'b1;
         c = wr_en ? (wr_data & DEF_BITS) : 32'h0;
         m_reg = (m_reg & ~c) | s;
         ude_hist.push_front(ude_n);
         void'(ude_hist.pop_back());
      end
   end

   function automatic string tag_of(input int b);
      if (b == 31) return "R6";
      if (b == 30) return "R5";
      if (b == 29 || b == 28) return "R7";
      if (b == 23 || b == 22) return "R3";
      if (b >= 16 && b <= 19) return "R4";
      if ((b >= 24 && b <= 27) || b == 15) return "R2";
      return "R8";
   endfunction

   always @(negedge clk) begin
      if (running && rst_n) begin
         logic [31:0] diff;
         bit exp_irq;
         diff = rd_data ^ m_reg;
         total++;
         if (diff != 0) begin
            int b = 31;
            while (b > 0 && !diff[b]) b--;
            bad++;
            $display("FAIL %s model compare: rd_data=%h expected=%h", tag_of(b), rd_data, m_reg);
         end
         exp_irq = msr_de && ((m_reg & IRQ_BITS) != 0);
         total++;
         if (irq !== exp_irq) begin
            bad++;
            $display("FAIL R10 model compare: irq=%0b expected=%0b", irq, exp_irq);
         end
      end
   end

   task automatic tick();
      @(posedge clk);
      #5;
   endtask

   task automatic check_bit(input int pos, input bit exp, input string tag);
      total++;
      if (rd_data[pos] !== exp) begin
         bad++;
         $display("FAIL %s bit %0d: actual=%0b expected=%0b", tag, pos, rd_data[pos], exp);
      end
   endtask

   task automatic check_word(input logic [31:0] exp, input string tag);
      total++;
      if (rd_data !== exp) begin
         bad++;
         $display("FAIL %s word: actual=%h expected=%h", tag, rd_data, exp);
      end
   endtask

   task automatic check_irq(input bit exp, input string tag);
      total++;
      if (irq !== exp) begin
         bad++;
         $display("FAIL %s irq: actual=%0b expected=%0b", tag, irq, exp);
      end
   endtask

   task automatic clear_all();
      wr_en = 1'b1; wr_data = 32'hFFFF_FFFF;
      tick();
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      int simple_pos[5] = '{27, 26, 25, 24, 15};
      repeat (3) @(posedge clk);
      #5 rst_n = 1'b1;
      running = 1'b1;
      tick();
      // R11 reset state
      check_word(32'h2000_0000, "R11");
      check_irq(1'b0, "R11");

      // R7 clearing the reset field, soft reset strobe
      wr_en = 1'b1; wr_data = 32'h3000_0000; tick(); wr_en = 1'b0; wr_data = '0;
      check_word(32'h0, "R7");
      soft_rst = 1'b1; tick(); soft_rst = 1'b0;
      check_bit(28, 1'b1, "R7");
      check_bit(29, 1'b0, "R7");
      clear_all();

      // R2 simple events with enable off and on, R10 irq
      msr_de = 1'b1;
      for (int i = 0; i < 5; i++) begin
         evt_en = '0; evt[i] = 1'b1; tick(); evt = '0;
         check_bit(simple_pos[i], 1'b0, "R2");
         evt_en[i] = 1'b1; evt[i] = 1'b1; tick(); evt = '0; evt_en = '0;
         check_bit(simple_pos[i], 1'b1, "R2");
         check_irq(1'b1, "R10");
         clear_all();
         check_irq(1'b0, "R10");
      end

      // R3 instruction-address compares
      for (int k = 0; k < 2; k++) begin
         iac_en = '0; iac_hit[k] = 1'b1; tick(); iac_hit = '0;
         check_bit(23 - k, 1'b0, "R3");
         iac_en[k] = 1'b1; iac_hit[k] = 1'b1; tick(); iac_hit = '0; iac_en = '0;
         check_bit(23 - k, 1'b1, "R3");
         clear_all();
      end

      // R4 data-address compare modes
      for (int k = 0; k < 2; k++) begin
         for (int m = 0; m < 4; m++) begin
            dac_mode = '0;
            dac_mode[2*k +: 2] = 2'(m);
            dac_rd[k] = 1'b1; tick(); dac_rd = '0;
            dac_wr[k] = 1'b1; tick(); dac_wr = '0;
            check_bit(19 - 2*k, m[1], "R4");
            check_bit(18 - 2*k, m[0], "R4");
            clear_all();
         end
      end
      dac_mode = '0;

      // R1 partial write-one-to-clear, writing zero
      evt_en = 5'b00011; evt = 5'b00011; tick(); evt = '0;
      wr_en = 1'b1; wr_data = 32'h0800_0000; tick();
      check_bit(27, 1'b0, "R1");
      check_bit(26, 1'b1, "R1");
      wr_data = 32'h0; tick(); wr_en = 1'b0;
      check_bit(26, 1'b1, "R1");

      // R8 reserved bits
      wr_en = 1'b1; wr_data = 32'h0030_7FFF; tick(); wr_en = 1'b0; wr_data = '0;
      check_word(32'h0400_0000, "R8");

      // R9 set wins over same-cycle clear
      evt = 5'b00001; wr_en = 1'b1; wr_data = 32'h0800_0000; tick();
      evt = '0; wr_en = 1'b0; wr_data = '0;
      check_bit(27, 1'b1, "R9");
      evt_en = '0;
      clear_all();

      // R5 unconditional pin
      idm = 1'b0; ude_n = 1'b0; repeat (5) tick(); ude_n = 1'b1; repeat (3) tick();
      check_bit(30, 1'b0, "R5");
      idm = 1'b1; ude_n = 1'b0; tick(); tick();
      check_bit(30, 1'b0, "R5");
      tick();
      check_bit(30, 1'b1, "R5");
      check_irq(1'b1, "R10");
      clear_all();
      repeat (4) tick();
      check_bit(30, 1'b0, "R5");
      ude_n = 1'b1; repeat (3) tick();
      clear_all();

      // R6 imprecise flag while masked
      msr_de = 1'b0; evt_en = 5'b01000; evt = 5'b01000; tick(); evt = '0;
      check_bit(31, 1'b1, "R6");
      check_bit(24, 1'b1, "R6");
      check_irq(1'b0, "R10");
      msr_de = 1'b1; #1;
      check_irq(1'b1, "R10");
      evt_en = '0;
      clear_all();
      check_word(32'h0, "R6");

      // mixed stress, model compared every clock
      for (int n = 0; n < 600; n++) begin
         evt = 5'($urandom); evt_en = 5'($urandom);
         iac_hit = 2'($urandom); iac_en = 2'($urandom);
         dac_rd = 2'($urandom); dac_wr = 2'($urandom); dac_mode = 4'($urandom);
         if (($urandom % 8) == 0) ude_n = ~ude_n;
         idm = 1'($urandom); msr_de = 1'($urandom);
         soft_rst = (($urandom % 16) == 0);
         wr_en = (($urandom % 4) == 0); wr_data = $urandom;
         tick();
      end
      evt = '0; iac_hit = '0; dac_rd = '0; dac_wr = '0; soft_rst = 1'b0; wr_en = 1'b0;
      repeat (4) tick();
      running = 1'b0;
      finish_run();
   end

endmodule